// File: doc/BRIEF.md
# Byte/Word DMA Data Formatter

This block repacks data between a link-side stream of 8-bit bytes and a host-side stream of 36-bit words. It works in both directions at once. The receive path packs incoming bytes into words for a host DMA channel. The transmit path unpacks host words into bytes for a packet buffer. A two-bit format input selects the packing layout. Three layouts exist: four bytes per word with zero padding, five bytes per word where only the low nibble of the fifth byte is kept, and a dense layout that puts nine bytes into two words and splits one byte across the word boundary.

Every external bus carries odd parity. Incoming byte and word parity is checked. Outgoing byte parity is generated. The parity of a packed word is predicted from the byte parities rather than recomputed from the assembled bits, so a corrupted byte, or a fault inside the repacking, shows up as wrong parity downstream. The packed word is also compared against its own recomputed parity inside the block. A flush request closes out a partially filled word. Three sticky flags report which check fired.

Every port uses a valid/ready handshake. The format code must be held constant while either path holds partial data.

Top module: `dma_byte_word_fmt`

## Requirements
- R1: With format code 00 (and the unused code 11), each group of four received bytes b0..b3 forms one word {b0,b1,b2,b3,4'h0}, with b0 in bits 35:28.
- R2: With format code 01, each group of five bytes forms {b0,b1,b2,b3,b4[3:0]}. The upper nibble of b4 is dropped.
- R3: With format code 10, each group of nine bytes forms two words. Word 0 is {b0,b1,b2,b3,b4[7:4]} and word 1 is {b4[3:0],b5,b6,b7,b8}.
- R4: The transmit path emits bytes in the inverse order of R1–R3. Code 00 emits bits 35:28 down to 11:4 and ignores bits 3:0. Code 01 adds a fifth byte {4'h0,bits 3:0}. Code 10 treats each pair of words as nine bytes.
- R5: A flush pulse emits any partially filled receive word with its unfilled bits zero, then restarts the packing phase. A flush with no bytes held emits nothing. No byte is accepted while a flush is asserted or pending.
- R6: Parity is odd. tx_byte_par makes {tx_byte,tx_byte_par} have an odd count of ones. When all input bytes carry good parity, the predicted rx_word_par also makes {rx_word,rx_word_par} odd.
- R7: A received byte with bad parity sets par_err[0]. The predicted parity of the word that byte is charged to comes out inverted, and par_err[2] (prediction mismatch) is set when that word is formed.
- R8: A transmit word with bad parity sets par_err[1]. Its bytes are still emitted unchanged.
- R9: par_err bits stay set until err_clr. Bit 0 is link side, bit 1 is host side, bit 2 is prediction. A new error in the same cycle as err_clr wins.
- R10: Under backpressure on either output, the held output stays valid and stable. No data is lost or duplicated.
- R11: After reset both output valids are low, par_err is zero, and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_mode | input | 2 | Packing layout: 00 four-byte, 01 five-byte, 10 dense, 11 as 00 |
| flush | input | 1 | Close out the partial receive word |
| err_clr | input | 1 | Clear the sticky parity flags |
| rx_byte | input | 8 | Received link byte |
| rx_byte_par | input | 1 | Odd parity of rx_byte |
| rx_byte_valid | input | 1 | rx_byte is offered |
| rx_byte_ready | output | 1 | Byte is taken this cycle |
| rx_word | output | 36 | Packed host word |
| rx_word_par | output | 1 | Predicted odd parity of rx_word |
| rx_word_valid | output | 1 | rx_word is offered |
| rx_word_ready | input | 1 | Host takes rx_word |
| tx_word | input | 36 | Host word to unpack |
| tx_word_par | input | 1 | Odd parity of tx_word |
| tx_word_valid | input | 1 | tx_word is offered |
| tx_word_ready | output | 1 | Word is taken this cycle |
| tx_byte | output | 8 | Unpacked link byte |
| tx_byte_par | output | 1 | Odd parity of tx_byte |
| tx_byte_valid | output | 1 | tx_byte is offered |
| tx_byte_ready | input | 1 | Link takes tx_byte |
| par_err | output | 3 | Sticky flags: link, host, prediction |

## Verification
The bench instantiates the block with its default setting, PRED_EN = 1. In that setting the receive word parity is the predicted value, not a fresh recomputation. This is the only setting in which a byte with corrupted parity can be seen from outside as an inverted word parity, so the prediction arithmetic, including the nibble corrections of the five-byte and dense layouts, is exposed at the ports. The recomputed-parity variant is not built by the bench. Random ready patterns on both outputs drive the flush-pending path and the dense layout's carried nibble through stalled cycles.

// File: rtl/bwf_pkg.sv
// Shared constants, format codes and parity helpers for the byte/word formatter.
// Assumes odd parity everywhere and a 36-bit word built from 8-bit bytes.
package bwf_pkg;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 36;
    localparam int NIB_W    = 4;
    localparam int HD_BYTES = 9;                 // dense layout: bytes per two words
    localparam int SPLIT_PH = WORD_W / BYTE_W;   // phase of the byte that is cut
    localparam int HD_LAST  = HD_BYTES - 1;
    localparam int PH_W     = $clog2(HD_BYTES);
    localparam int N_ERR    = 3;

    typedef enum logic [1:0] {
        FMT_IC  = 2'b00,
        FMT_CD  = 2'b01,
        FMT_HD  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    function automatic logic odd_par8(input logic [BYTE_W-1:0] d);
        return ~^d;
    endfunction

    function automatic logic odd_par36(input logic [WORD_W-1:0] d);
        return ~^d;
    endfunction
endpackage

// File: rtl/bwf_pack.sv
// Receive packer: byte stream in, 36-bit words out, one word of output storage.
// Word parity is predicted from the byte parities, with a correction for the nibble
// that is dropped or carried. Assumes mode is stable while bytes are held.
module bwf_pack
    import bwf_pkg::*;
#(
    parameter bit PRED_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              mode,
    input  logic              flush,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_par,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_par,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              link_fault,
    output logic              pred_fault
);
    logic [WORD_W-1:0] acc_q, acc_n, carry_n, odata_q, load_data;
    logic              accx_q, accx_n, carry_x_n, opred_q, ovalid_q, load_pred;
    logic [PH_W-1:0]   ph_q, ph_n;
    logic              done, fpend_q, flush_req, slot_free, take, drain, load, byte_x;

    // Place the offered byte according to the current phase and layout.
    always_comb begin
        acc_n     = acc_q;
        accx_n    = accx_q;
        carry_n   = '0;
        carry_x_n = 1'b0;
        done      = 1'b0;
        ph_n      = ph_q + 1'b1;
        byte_x    = ~in_par;
        if (ph_q < PH_W'(SPLIT_PH)) begin
            acc_n[WORD_W-1-BYTE_W*int'(ph_q) -: BYTE_W] = in_data;
            accx_n = accx_q ^ byte_x;
            done   = (ph_q == PH_W'(SPLIT_PH-1)) && (mode == FMT_IC || mode == FMT_RSV);
        end else if (mode == FMT_CD) begin
            acc_n[NIB_W-1:0] = in_data[NIB_W-1:0];
            accx_n = accx_q ^ byte_x ^ (^in_data[BYTE_W-1:NIB_W]);
            done   = 1'b1;
        end else if (ph_q == PH_W'(SPLIT_PH)) begin
            acc_n[NIB_W-1:0] = in_data[BYTE_W-1:NIB_W];
            accx_n = accx_q ^ byte_x ^ (^in_data[NIB_W-1:0]);
            done   = 1'b1;
            carry_n[WORD_W-1 -: NIB_W] = in_data[NIB_W-1:0];
            carry_x_n = ^in_data[NIB_W-1:0];
        end else begin
            acc_n[WORD_W-1-NIB_W-BYTE_W*(int'(ph_q)-SPLIT_PH-1) -: BYTE_W] = in_data;
            accx_n = accx_q ^ byte_x;
            done   = (ph_q == PH_W'(HD_LAST));
        end
        if (done && !(mode == FMT_HD && ph_q == PH_W'(SPLIT_PH)))
            ph_n = '0;
    end

    assign slot_free  = !ovalid_q || out_ready;
    assign flush_req  = flush || fpend_q;
    assign in_ready   = slot_free && !flush_req;
    assign take       = in_valid && in_ready;
    assign drain      = flush_req && slot_free && (ph_q != '0);
    assign load       = (take && done) || drain;
    assign load_data  = take ? acc_n : acc_q;
    assign load_pred  = ~(take ? accx_n : accx_q);
    assign pred_fault = load && (load_pred != odd_par36(load_data));
    assign link_fault = take && (in_par != odd_par8(in_data));

    // Output slot, working word, phase and flush-pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovalid_q <= 1'b0;
            odata_q  <= '0;
            opred_q  <= 1'b0;
            acc_q    <= '0;
            accx_q   <= 1'b0;
            ph_q     <= '0;
            fpend_q  <= 1'b0;
        end else begin
            if (load) begin
                ovalid_q <= 1'b1;
                odata_q  <= load_data;
                opred_q  <= load_pred;
            end else if (out_ready) begin
                ovalid_q <= 1'b0;
            end
            if (take) begin
                acc_q  <= done ? carry_n : acc_n;
                accx_q <= done ? carry_x_n : accx_n;
                ph_q   <= ph_n;
            end else if (flush_req && slot_free) begin
                acc_q  <= '0;
                accx_q <= 1'b0;
                ph_q   <= '0;
            end
            fpend_q <= flush_req && !slot_free;
        end
    end

    assign out_data  = odata_q;
    assign out_valid = ovalid_q;

    generate
        if (PRED_EN) begin : g_pred
            assign out_par = opred_q;
        end else begin : g_regen
            assign out_par = odd_par36(odata_q);
        end
    endgenerate
endmodule

// File: rtl/bwf_unpack.sv
// Transmit unpacker: one held host word, bytes offered straight from it by phase.
// In the dense layout the low nibble of the first word is kept for the split byte.
// Assumes mode is stable while a word or nibble is held.
module bwf_unpack
    import bwf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              mode,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_par,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_par,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              host_fault
);
    logic [WORD_W-1:0] uw_q;
    logic              full_q, last, keep_nib, pop, load;
    logic [PH_W-1:0]   ph_q, ph_n;
    logic [NIB_W-1:0]  nib_q;

    // Select the byte for this phase and note whether the word is used up.
    always_comb begin
        out_data = '0;
        last     = 1'b0;
        keep_nib = 1'b0;
        ph_n     = ph_q + 1'b1;
        if (ph_q < PH_W'(SPLIT_PH)) begin
            out_data = uw_q[WORD_W-1-BYTE_W*int'(ph_q) -: BYTE_W];
            if (ph_q == PH_W'(SPLIT_PH-1)) begin
                last     = (mode != FMT_CD);
                keep_nib = (mode == FMT_HD);
            end
        end else if (mode == FMT_CD) begin
            out_data = {{NIB_W{1'b0}}, uw_q[NIB_W-1:0]};
            last     = 1'b1;
        end else if (ph_q == PH_W'(SPLIT_PH)) begin
            out_data = {nib_q, uw_q[WORD_W-1 -: NIB_W]};
        end else begin
            out_data = uw_q[WORD_W-1-NIB_W-BYTE_W*(int'(ph_q)-SPLIT_PH-1) -: BYTE_W];
            last     = (ph_q == PH_W'(HD_LAST));
        end
        if (last && !keep_nib)
            ph_n = '0;
    end

    assign out_valid  = full_q;
    assign out_par    = odd_par8(out_data);
    assign pop        = full_q && out_ready;
    assign in_ready   = !full_q || (pop && last);
    assign load       = in_valid && in_ready;
    assign host_fault = load && (in_par != odd_par36(in_data));

    // Held word, phase and carried nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uw_q   <= '0;
            full_q <= 1'b0;
            ph_q   <= '0;
            nib_q  <= '0;
        end else begin
            if (pop) begin
                ph_q <= ph_n;
                if (keep_nib)
                    nib_q <= uw_q[NIB_W-1:0];
            end
            if (load) begin
                uw_q   <= in_data;
                full_q <= 1'b1;
            end else if (pop && last) begin
                full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bwf_errs.sv
// Sticky error flags: each hit pulse sets its bit, clear drops all, a hit beats a clear.
module bwf_errs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] hit,
    output logic [N-1:0] flags
);
    // Hold, clear or set the flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (clr ? '0 : flags) | hit;
    end
endmodule

// File: rtl/dma_byte_word_fmt.sv
// Top of the byte/word formatter: receive packer, transmit unpacker and sticky
// parity flags. The two directions are independent and share only the format code.
module dma_byte_word_fmt
    import bwf_pkg::*;
#(
    parameter bit PRED_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_mode,
    input  logic              flush,
    input  logic              err_clr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_byte_par,
    input  logic              rx_byte_valid,
    output logic              rx_byte_ready,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_word_par,
    output logic              rx_word_valid,
    input  logic              rx_word_ready,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_word_par,
    input  logic              tx_word_valid,
    output logic              tx_word_ready,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_byte_par,
    output logic              tx_byte_valid,
    input  logic              tx_byte_ready,
    output logic [N_ERR-1:0]  par_err
);
    fmt_e mode;
    logic link_fault, host_fault, pred_fault;

    assign mode = fmt_e'(fmt_mode);

    bwf_pack #(.PRED_EN(PRED_EN)) u_pack (
        .clk(clk), .rst_n(rst_n), .mode(mode), .flush(flush),
        .in_data(rx_byte), .in_par(rx_byte_par), .in_valid(rx_byte_valid),
        .in_ready(rx_byte_ready), .out_data(rx_word), .out_par(rx_word_par),
        .out_valid(rx_word_valid), .out_ready(rx_word_ready),
        .link_fault(link_fault), .pred_fault(pred_fault)
    );

    bwf_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_data(tx_word), .in_par(tx_word_par), .in_valid(tx_word_valid),
        .in_ready(tx_word_ready), .out_data(tx_byte), .out_par(tx_byte_par),
        .out_valid(tx_byte_valid), .out_ready(tx_byte_ready),
        .host_fault(host_fault)
    );

    bwf_errs #(.N(N_ERR)) u_errs (
        .clk(clk), .rst_n(rst_n), .clr(err_clr),
        .hit({pred_fault, host_fault, link_fault}),
        .flags(par_err)
    );
endmodule

// File: rtl/bwf_checker.sv
// Port-level temporal checks for the formatter, bound to the top module.
module bwf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  fmt_mode,
    input logic        flush,
    input logic        err_clr,
    input logic [7:0]  rx_byte,
    input logic        rx_byte_par,
    input logic        rx_byte_valid,
    input logic        rx_byte_ready,
    input logic [35:0] rx_word,
    input logic        rx_word_par,
    input logic        rx_word_valid,
    input logic        rx_word_ready,
    input logic [35:0] tx_word,
    input logic        tx_word_par,
    input logic        tx_word_valid,
    input logic        tx_word_ready,
    input logic        tx_byte_valid,
    input logic        tx_byte_ready,
    input logic [2:0]  par_err
);
    a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid && !rx_word_ready |=> rx_word_valid && $stable(rx_word) && $stable(rx_word_par));

    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_byte_valid && !tx_byte_ready |=> tx_byte_valid);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((par_err & $past(par_err)) == $past(par_err)));

    a_r7_link_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_valid && rx_byte_ready && !(^{rx_byte, rx_byte_par}) |=> par_err[0]);

    a_r8_host_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_valid && tx_word_ready && !(^{tx_word, tx_word_par}) |=> par_err[1]);

    a_r1_ic_pad: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid && (fmt_mode == 2'b00 || fmt_mode == 2'b11) |-> rx_word[3:0] == 4'h0);

    a_r5_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rx_byte_ready);
endmodule

bind dma_byte_word_fmt bwf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .flush(flush), .err_clr(err_clr),
    .rx_byte(rx_byte), .rx_byte_par(rx_byte_par), .rx_byte_valid(rx_byte_valid),
    .rx_byte_ready(rx_byte_ready), .rx_word(rx_word), .rx_word_par(rx_word_par),
    .rx_word_valid(rx_word_valid), .rx_word_ready(rx_word_ready),
    .tx_word(tx_word), .tx_word_par(tx_word_par), .tx_word_valid(tx_word_valid),
    .tx_word_ready(tx_word_ready), .tx_byte_valid(tx_byte_valid),
    .tx_byte_ready(tx_byte_ready), .par_err(par_err)
);

// File: tb/sim_dma_byte_word_fmt.sv
`timescale 1ns/1ps
module sim_dma_byte_word_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_mode = 2'b00;
    logic        flush = 1'b0, err_clr = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_par = 1'b0, rx_byte_valid = 1'b0, rx_byte_ready;
    logic [35:0] rx_word;
    logic        rx_word_par, rx_word_valid, rx_word_ready = 1'b1;
    logic [35:0] tx_word = '0;
    logic        tx_word_par = 1'b0, tx_word_valid = 1'b0, tx_word_ready;
    logic [7:0]  tx_byte;
    logic        tx_byte_par, tx_byte_valid, tx_byte_ready = 1'b1;
    logic [2:0]  par_err;

    always #2.5 clk = ~clk;

    dma_byte_word_fmt u0 (
        .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .flush(flush), .err_clr(err_clr),
        .rx_byte(rx_byte), .rx_byte_par(rx_byte_par), .rx_byte_valid(rx_byte_valid),
        .rx_byte_ready(rx_byte_ready), .rx_word(rx_word), .rx_word_par(rx_word_par),
        .rx_word_valid(rx_word_valid), .rx_word_ready(rx_word_ready),
        .tx_word(tx_word), .tx_word_par(tx_word_par), .tx_word_valid(tx_word_valid),
        .tx_word_ready(tx_word_ready), .tx_byte(tx_byte), .tx_byte_par(tx_byte_par),
        .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready), .par_err(par_err)
    );

    int    checks = 0, fails = 0, cyc = 0;
    string cur_req = "R11";
    bit    stall_rx = 1'b0, stall_tx = 1'b0;
    logic [36:0] exp_w[$];
    logic [8:0]  exp_b[$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference sink model: each accepted output is compared with the next expected item.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_word_valid && rx_word_ready) begin
                if (exp_w.size() == 0) begin
                    check(cur_req, {27'd0, rx_word_par, rx_word}, 64'hFFFF_FFFF_FFFF_FFFF, "unexpected word");
                end else begin
                    logic [36:0] e;
                    e = exp_w.pop_front();
                    check(cur_req, {28'd0, rx_word}, {28'd0, e[35:0]}, "word data");
                    check((cur_req == "R7") ? "R7" : "R6", {63'd0, rx_word_par}, {63'd0, e[36]}, "word parity");
                end
            end
            if (tx_byte_valid && tx_byte_ready) begin
                if (exp_b.size() == 0) begin
                    check(cur_req, {55'd0, tx_byte_par, tx_byte}, 64'hFFFF_FFFF_FFFF_FFFF, "unexpected byte");
                end else begin
                    logic [8:0] e;
                    e = exp_b.pop_front();
                    check(cur_req, {56'd0, tx_byte}, {56'd0, e[7:0]}, "byte data");
                    check("R6", {63'd0, tx_byte_par}, {63'd0, e[8]}, "byte parity");
                end
            end
        end
    end

    // Sink readiness, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        rx_word_ready = stall_rx ? 1'($urandom_range(0, 1)) : 1'b1;
        tx_byte_ready = stall_tx ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] d, input logic p);
        rx_byte = d; rx_byte_par = p; rx_byte_valid = 1'b1;
        do @(negedge clk); while (!rx_byte_ready);
        @(posedge clk); #1;
        rx_byte_valid = 1'b0;
    endtask

    task automatic send_word(input logic [35:0] d, input logic p);
        tx_word = d; tx_word_par = p; tx_word_valid = 1'b1;
        do @(negedge clk); while (!tx_word_ready);
        @(posedge clk); #1;
        tx_word_valid = 1'b0;
    endtask

    task automatic send_bytes(input logic [7:0] b[$], input int bad);
        for (int j = 0; j < b.size(); j++)
            send_byte(b[j], (~^b[j]) ^ (j == bad));
    endtask

    task automatic send_words(input logic [35:0] w[$], input int bad);
        for (int j = 0; j < w.size(); j++)
            send_word(w[j], (~^w[j]) ^ (j == bad));
    endtask

    // Behavioural packing model: build the expected words, with the bad byte's parity charged.
    task automatic expect_pack(input logic [1:0] m, input logic [7:0] b[$], input int bad);
        int per;
        per = (m == 2'd1) ? 5 : (m == 2'd2) ? 9 : 4;
        for (int c = 0; c < b.size(); c += per) begin
            logic [71:0] s;
            logic [35:0] w;
            int          k;
            logic        f0, f1;
            s = '0;
            k = b.size() - c;
            if (k > per) k = per;
            for (int j = 0; j < k; j++) s[71-8*j -: 8] = b[c+j];
            f0 = (bad >= c) && (bad < c + ((m == 2'd2) ? 5 : per));
            f1 = (m == 2'd2) && (bad >= c + 5) && (bad < c + 9);
            if (m == 2'd2) begin
                exp_w.push_back({(~^s[71:36]) ^ f0, s[71:36]});
                if (k >= 5) exp_w.push_back({(~^s[35:0]) ^ f1, s[35:0]});
            end else begin
                w = (m == 2'd1) ? {s[71:40], s[35:32]} : {s[71:40], 4'h0};
                exp_w.push_back({(~^w) ^ f0, w});
            end
        end
    endtask

    task automatic push_b(input logic [7:0] b);
        exp_b.push_back({~^b, b});
    endtask

    // Behavioural unpacking model.
    task automatic expect_unpack(input logic [1:0] m, input logic [35:0] w[$]);
        if (m == 2'd2) begin
            for (int i = 0; i + 1 < w.size(); i += 2) begin
                logic [71:0] s;
                s = {w[i], w[i+1]};
                for (int j = 0; j < 9; j++) push_b(s[71-8*j -: 8]);
            end
        end else begin
            for (int i = 0; i < w.size(); i++) begin
                for (int j = 0; j < 4; j++) push_b(w[i][35-8*j -: 8]);
                if (m == 2'd1) push_b({4'h0, w[i][3:0]});
            end
        end
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while ((exp_w.size() != 0 || exp_b.size() != 0) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(req, {32'd0, 32'(exp_w.size() + exp_b.size())}, 64'd0, "outstanding items");
        repeat (6) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic do_flush(input string req);
        flush = 1'b1;
        @(negedge clk);
        check(req, {63'd0, rx_byte_ready}, 64'd0, "ready during flush");
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    task automatic make_bytes(output logic [7:0] q[$], input int n, input int seed);
        q = {};
        for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + seed * 11 + 5) ^ (i << 3)));
    endtask

    initial begin
        logic [7:0]  bq[$];
        logic [35:0] wq[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R11";
        check("R11", {63'd0, rx_word_valid}, 64'd0, "rx_word_valid after reset");
        check("R11", {63'd0, tx_byte_valid}, 64'd0, "tx_byte_valid after reset");
        check("R11", {61'd0, par_err}, 64'd0, "par_err after reset");
        check("R11", {63'd0, rx_byte_ready}, 64'd1, "rx_byte_ready after reset");
        check("R11", {63'd0, tx_word_ready}, 64'd1, "tx_word_ready after reset");
        @(posedge clk); #1;

        // R1 four-byte layout, free-running and then stalled (R10), plus code 11.
        cur_req = "R1"; fmt_mode = 2'b00;
        make_bytes(bq, 8, 1); expect_pack(2'b00, bq, -1); send_bytes(bq, -1); drain("R1");
        cur_req = "R10"; stall_rx = 1'b1;
        make_bytes(bq, 12, 2); expect_pack(2'b00, bq, -1); send_bytes(bq, -1); drain("R10");
        cur_req = "R1"; fmt_mode = 2'b11;
        make_bytes(bq, 4, 3); expect_pack(2'b00, bq, -1); send_bytes(bq, -1); drain("R1");

        // R2 five-byte layout under stall.
        cur_req = "R2"; fmt_mode = 2'b01;
        make_bytes(bq, 10, 4); expect_pack(2'b01, bq, -1); send_bytes(bq, -1); drain("R2");

        // R3 dense layout under stall.
        cur_req = "R3"; fmt_mode = 2'b10;
        make_bytes(bq, 18, 5); expect_pack(2'b10, bq, -1); send_bytes(bq, -1); drain("R3");

        // R5 flush: mid-word, after the split byte, early in a dense pair, and empty.
        cur_req = "R5"; fmt_mode = 2'b00;
        make_bytes(bq, 6, 6); expect_pack(2'b00, bq, -1); send_bytes(bq, -1); do_flush("R5"); drain("R5");
        fmt_mode = 2'b10;
        make_bytes(bq, 5, 7); expect_pack(2'b10, bq, -1); send_bytes(bq, -1); do_flush("R5"); drain("R5");
        make_bytes(bq, 3, 8); expect_pack(2'b10, bq, -1); send_bytes(bq, -1); do_flush("R5"); drain("R5");
        do_flush("R5"); drain("R5");
        fmt_mode = 2'b01;
        make_bytes(bq, 7, 9); expect_pack(2'b01, bq, -1); send_bytes(bq, -1); do_flush("R5"); drain("R5");
        stall_rx = 1'b0;

        // R7 corrupted byte parity carried into the word, flags link and prediction.
        cur_req = "R7"; fmt_mode = 2'b00;
        make_bytes(bq, 4, 10); expect_pack(2'b00, bq, 1); send_bytes(bq, 1); drain("R7");
        @(negedge clk);
        check("R7", {61'd0, par_err}, 64'd5, "flags after bad byte");
        @(posedge clk); #1;
        err_clr = 1'b1; @(posedge clk); #1; err_clr = 1'b0;
        @(negedge clk);
        check("R9", {61'd0, par_err}, 64'd0, "flags after clear");
        @(posedge clk); #1;

        // R4 unpacking in each layout, with byte-side stall.
        cur_req = "R4"; stall_tx = 1'b1; fmt_mode = 2'b00;
        wq = {36'h1234_5678_9, 36'hABCD_EF01_F, 36'h0F0F_0F0F_3};
        expect_unpack(2'b00, wq); send_words(wq, -1); drain("R4");
        fmt_mode = 2'b01;
        wq = {36'h8765_4321_A, 36'hFEDC_BA98_5};
        expect_unpack(2'b01, wq); send_words(wq, -1); drain("R4");
        fmt_mode = 2'b10;
        wq = {36'h1122_3344_5, 36'h6778_899A_A, 36'hC0FF_EE12_3, 36'h4567_89AB_C};
        expect_unpack(2'b10, wq); send_words(wq, -1); drain("R4");
        stall_tx = 1'b0;

        // R8 bad host word parity; R9 the flag stays set until cleared.
        cur_req = "R8"; fmt_mode = 2'b00;
        wq = {36'h5A5A_A5A5_0};
        expect_unpack(2'b00, wq); send_words(wq, 0); drain("R8");
        @(negedge clk);
        check("R8", {61'd0, par_err}, 64'd2, "flags after bad word");
        repeat (5) @(negedge clk);
        check("R9", {61'd0, par_err}, 64'd2, "flag held");
        @(posedge clk); #1;
        err_clr = 1'b1; @(posedge clk); #1; err_clr = 1'b0;
        @(negedge clk);
        check("R9", {61'd0, par_err}, 64'd0, "flags cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule